// File: doc/BRIEF.md
# Display Link Interrupt Error Recovery Sequencer

This block services the 32-bit interrupt status word of a serial display link controller. A single `start` pulse makes it take a snapshot of the status word. It then visits every position of that snapshot in ascending order and runs a fixed recovery action for each set bit. Only the generic-FIFO-full causes need real work. For each of these, the engine clears the cause with a one-cycle write-one-to-clear strobe and mask. It then polls the FIFO status word until the required FIFO-empty bits are all high. Each poll is separated by a programmable interval built from a microsecond prescaler, and the number of polls is limited by a budget.

After each serviced position the engine reads the live interrupt status again. If that cause is still pending, it records it. At the end of the walk, `done` pulses for one cycle. Two sticky flags report whether any FIFO wait used up its budget and whether any cause stayed set. Both flags stay valid until the next start. A build option turns the two link contention causes into "drain everything" waits, which wait for every generic FIFO to be empty. By default these causes take no action.

Top module: `dsi_irq_recovery`

## Requirements
- R1: While and after reset, `busy`, `done`, `clr_strobe`, `err_timeout` and `err_uncleared` are 0 and `clr_mask` is all zeros.
- R2: A `start` seen while idle captures `irq_status`. Snapshot positions are then visited from bit 0 up to bit 31, one position per cycle, so clear strobes appear in ascending bit order.
- R3: A pending bit in 23..27 (high-speed FIFO full) produces exactly one `clr_strobe` cycle whose `clr_mask` has only that bit set. The wait that follows is satisfied only when `fifo_status` bits 2 and 18 are both 1.
- R4: A pending bit 28 (low-power FIFO full) is cleared the same way. Its wait is satisfied only when `fifo_status` bits 10 and 26 are both 1.
- R5: Pending bits 0..22 and 29..31 never appear in `clr_mask`. With the default build, each costs exactly one extra cycle. With an all-zero snapshot, `done` is high in the 32nd cycle after the start edge.
- R6: A FIFO wait polls first in its first cycle and then every `CYC_PER_US*POLL_US` cycles, for at most `POLL_LIMIT` polls. If the last poll finds the condition unmet, `err_timeout` is set and the walk continues.
- R7: After each serviced bit, if that bit of the live `irq_status` is still 1, `err_uncleared` is set.
- R8: `done` is a single-cycle pulse with `busy` low afterwards. Both error flags are cleared on an accepted start and otherwise held. A `start` while busy is ignored.
- R9: With `DRAIN_ON_CONTENTION=1`, pending bits 18 and 19 are not strobed and wait until `fifo_status` bits 2, 10, 18, 26, 27 and 28 are all 1. With the default build they get no action.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin one servicing pass (accepted while idle) |
| irq_status | input | STAT_W | Live interrupt status word |
| fifo_status | input | STAT_W | Live generic FIFO status word |
| busy | output | 1 | Pass in progress |
| clr_strobe | output | 1 | Write-one-to-clear strobe |
| clr_mask | output | STAT_W | One-hot bit to clear, zero when no strobe |
| done | output | 1 | One-cycle end-of-pass pulse |
| err_timeout | output | 1 | Sticky: a FIFO wait used up its poll budget |
| err_uncleared | output | 1 | Sticky: a serviced cause was still set afterwards |

## Verification
A wrong bit index or snapshot shows up as a clear strobe with the wrong mask or in the wrong order. It appears at the port within one cycle of the visit. A bad classification or empty mask shows up as a timeout flag that contradicts the FIFO status the bench supplied. A miscounted poll interval or budget moves `done` by whole intervals relative to the strobe, so the tests measure the strobe-to-done distance exactly and move FIFO drain onto the last possible poll and one cycle past it. A walk that skips or repeats a position changes the fixed start-to-done latency of the empty pass.

// File: rtl/dsi_rec_pkg.sv
// Shared types and fixed bit positions for the interrupt recovery sequencer.
// Assumes a 32-bit status layout; positions below are decoded by neighbours.
package dsi_rec_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SCAN,
        ST_ACK,
        ST_WAIT,
        ST_CHECK,
        ST_DONE
    } rec_state_t;

    typedef enum logic [1:0] {
        ACT_NONE,
        ACT_ACK_WAIT,
        ACT_WAIT
    } rec_action_t;

    // interrupt causes
    localparam int HS_FULL_FIRST = 23;
    localparam int HS_FULL_LAST  = 27;
    localparam int LP_FULL_BIT   = 28;
    localparam int CONTEND_HI    = 18;
    localparam int CONTEND_LO    = 19;

    // FIFO-empty indications in the FIFO status word
    localparam int HS_CMD_EMPTY  = 2;
    localparam int HS_DAT_EMPTY  = 18;
    localparam int LP_CMD_EMPTY  = 10;
    localparam int LP_DAT_EMPTY  = 26;
    localparam int EXTRA_EMPTY_A = 27;
    localparam int EXTRA_EMPTY_B = 28;

endpackage

// File: rtl/rec_bit_class.sv
// Maps a status bit index to its recovery action and the FIFO-empty bits
// that must all be high before the action is complete.
// Assumes STAT_W >= 32. DRAIN_ON_CONTENTION selects the contention variant.
module rec_bit_class
    import dsi_rec_pkg::*;
#(
    parameter int STAT_W              = 32,
    parameter bit DRAIN_ON_CONTENTION = 1'b0,
    localparam int IDX_W              = $clog2(STAT_W)
) (
    input  logic [IDX_W-1:0]  idx,
    output rec_action_t       action,
    output logic [STAT_W-1:0] need
);

    localparam logic [STAT_W-1:0] ONE      = STAT_W'(1);
    localparam logic [STAT_W-1:0] HS_NEED  = (ONE << HS_CMD_EMPTY) | (ONE << HS_DAT_EMPTY);
    localparam logic [STAT_W-1:0] LP_NEED  = (ONE << LP_CMD_EMPTY) | (ONE << LP_DAT_EMPTY);
    localparam logic [STAT_W-1:0] ALL_NEED = HS_NEED | LP_NEED |
                                             (ONE << EXTRA_EMPTY_A) | (ONE << EXTRA_EMPTY_B);

    logic contend_hit;

    // variant select: contention causes either drain all FIFOs or do nothing
    generate
        if (DRAIN_ON_CONTENTION) begin : g_drain
            assign contend_hit = (int'(idx) == CONTEND_HI) || (int'(idx) == CONTEND_LO);
        end else begin : g_nodrain
            assign contend_hit = 1'b0;
        end
    endgenerate

    // purpose: choose the action and the empty-bit set for the visited index
    always_comb begin
        action = ACT_NONE;
        need   = '0;
        if (int'(idx) >= HS_FULL_FIRST && int'(idx) <= HS_FULL_LAST) begin
            action = ACT_ACK_WAIT;
            need   = HS_NEED;
        end else if (int'(idx) == LP_FULL_BIT) begin
            action = ACT_ACK_WAIT;
            need   = LP_NEED;
        end else if (contend_hit) begin
            action = ACT_WAIT;
            need   = ALL_NEED;
        end
    end

endmodule

// File: rtl/rec_poll_timer.sv
// Poll interval timer: a microsecond prescaler feeding a microsecond counter.
// After a restart it pulses expire exactly CYC_PER_US*POLL_US cycles later
// and then stops until the next restart. Assumes both parameters are >= 1.
module rec_poll_timer #(
    parameter int CYC_PER_US = 100,
    parameter int POLL_US    = 100,
    localparam int PRE_W     = $clog2(CYC_PER_US + 1),
    localparam int US_W      = $clog2(POLL_US + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic expire
);

    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CYC_PER_US - 1);
    localparam logic [US_W-1:0]  US_LAST  = US_W'(POLL_US - 1);

    logic             running;
    logic [PRE_W-1:0] pre_cnt;
    logic [US_W-1:0]  us_cnt;

    assign expire = running && (pre_cnt == PRE_LAST) && (us_cnt == US_LAST);

    // purpose: count prescaler cycles and elapsed microseconds while armed
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running <= 1'b0;
            pre_cnt <= '0;
            us_cnt  <= '0;
        end else if (restart) begin
            running <= 1'b1;
            pre_cnt <= '0;
            us_cnt  <= '0;
        end else if (running) begin
            if (pre_cnt == PRE_LAST) begin
                pre_cnt <= '0;
                if (us_cnt == US_LAST) begin
                    us_cnt  <= '0;
                    running <= 1'b0;
                end else begin
                    us_cnt <= us_cnt + 1'b1;
                end
            end else begin
                pre_cnt <= pre_cnt + 1'b1;
            end
        end
    end

    // R6
    expire_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !restart) |=> !expire);

endmodule

// File: rtl/dsi_irq_recovery.sv
// Interrupt error recovery sequencer. On start it snapshots the interrupt
// status and visits each position in ascending order. FIFO-full causes are
// cleared with a one-hot write-one-to-clear strobe, then a bounded poll waits
// for the matching FIFO-empty bits. Every serviced cause is re-read live and
// flagged if still set. Assumes the clear takes effect by the next cycle.
module dsi_irq_recovery
    import dsi_rec_pkg::*;
#(
    parameter int STAT_W              = 32,
    parameter int CYC_PER_US          = 100,
    parameter int POLL_US             = 100,
    parameter int POLL_LIMIT          = 65535,
    parameter bit DRAIN_ON_CONTENTION = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [STAT_W-1:0] irq_status,
    input  logic [STAT_W-1:0] fifo_status,
    output logic              busy,
    output logic              clr_strobe,
    output logic [STAT_W-1:0] clr_mask,
    output logic              done,
    output logic              err_timeout,
    output logic              err_uncleared
);

    localparam int IDX_W = $clog2(STAT_W);
    localparam int PC_W  = $clog2(POLL_LIMIT + 1);
    localparam logic [IDX_W-1:0]  LAST_IDX  = IDX_W'(STAT_W - 1);
    localparam logic [PC_W-1:0]   LAST_POLL = PC_W'(POLL_LIMIT - 1);
    localparam logic [STAT_W-1:0] ONE       = STAT_W'(1);
    localparam logic [STAT_W-1:0] ACKABLE   = ((ONE << (LP_FULL_BIT + 1)) - ONE) &
                                              ~((ONE << HS_FULL_FIRST) - ONE);

    rec_state_t        state;
    logic [STAT_W-1:0] snap;
    logic [IDX_W-1:0]  idx;
    logic [PC_W-1:0]   poll_cnt;
    logic              poll_now;
    logic              err_to_q;
    logic              err_uc_q;

    rec_action_t       action;
    logic [STAT_W-1:0] need;
    logic              met;
    logic              poll_due;
    logic              tmr_restart;
    logic              tmr_expire;

    rec_bit_class #(
        .STAT_W              (STAT_W),
        .DRAIN_ON_CONTENTION (DRAIN_ON_CONTENTION)
    ) class_i (
        .idx    (idx),
        .action (action),
        .need   (need)
    );

    rec_poll_timer #(
        .CYC_PER_US (CYC_PER_US),
        .POLL_US    (POLL_US)
    ) timer_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (tmr_restart),
        .expire  (tmr_expire)
    );

    // purpose: evaluate the FIFO-empty condition and decide on re-arming
    always_comb begin
        met         = ((fifo_status & need) == need);
        poll_due    = (state == ST_WAIT) && (poll_now || tmr_expire);
        tmr_restart = poll_due && !met && (poll_cnt != LAST_POLL);
    end

    assign busy          = (state != ST_IDLE);
    assign done          = (state == ST_DONE);
    assign clr_strobe    = (state == ST_ACK);
    assign clr_mask      = clr_strobe ? (ONE << idx) : '0;
    assign err_timeout   = err_to_q;
    assign err_uncleared = err_uc_q;

    // purpose: sequence snapshot walk, clear, bounded wait and re-check
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            snap     <= '0;
            idx      <= '0;
            poll_cnt <= '0;
            poll_now <= 1'b0;
            err_to_q <= 1'b0;
            err_uc_q <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        snap     <= irq_status;
                        idx      <= '0;
                        err_to_q <= 1'b0;
                        err_uc_q <= 1'b0;
                        state    <= ST_SCAN;
                    end
                end
                ST_SCAN: begin
                    if (snap[idx]) begin
                        case (action)
                            ACT_ACK_WAIT: state <= ST_ACK;
                            ACT_WAIT: begin
                                poll_cnt <= '0;
                                poll_now <= 1'b1;
                                state    <= ST_WAIT;
                            end
                            default: state <= ST_CHECK;
                        endcase
                    end else if (idx == LAST_IDX) begin
                        state <= ST_DONE;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                ST_ACK: begin
                    poll_cnt <= '0;
                    poll_now <= 1'b1;
                    state    <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (poll_due) begin
                        poll_now <= 1'b0;
                        if (met) begin
                            state <= ST_CHECK;
                        end else if (poll_cnt == LAST_POLL) begin
                            err_to_q <= 1'b1;
                            state    <= ST_CHECK;
                        end else begin
                            poll_cnt <= poll_cnt + 1'b1;
                        end
                    end
                end
                ST_CHECK: begin
                    if (irq_status[idx]) begin
                        err_uc_q <= 1'b1;
                    end
                    if (idx == LAST_IDX) begin
                        state <= ST_DONE;
                    end else begin
                        idx   <= idx + 1'b1;
                        state <= ST_SCAN;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R3
    clr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_strobe |-> ($countones(clr_mask) == 1));

    // R5
    clr_scope_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_strobe |-> ((clr_mask & ~ACKABLE) == '0));

    // R6
    poll_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT) |-> (poll_cnt <= LAST_POLL));

    // R7
    uncleared_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_CHECK) && irq_status[idx]) |=> err_uncleared);

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    // R8
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(err_timeout) && $stable(err_uncleared)));

endmodule

// File: tb/dsi_irq_recovery_tb_top.sv
// Directed bench: a behavioural interrupt register that honours the clear
// strobes, two instances (default and contention-drain), one task per case.
module dsi_irq_recovery_tb_top;

    localparam int W     = 32;
    localparam int CPU   = 2;
    localparam int PUS   = 2;
    localparam int LIMIT = 3;
    localparam int IVL   = CPU * PUS;

    localparam logic [31:0] HS_E  = 32'h0004_0004;
    localparam logic [31:0] LP_E  = 32'h0400_0400;
    localparam logic [31:0] ALL_E = 32'h1C04_0404;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          start_c = 1'b0;
    logic [W-1:0]  irq_q;
    logic [W-1:0]  fifo = '0;
    logic          load_req = 1'b0;
    logic [W-1:0]  load_val = '0;

    logic          busy_i, strobe_i, done_i, to_i, uc_i;
    logic [W-1:0]  mask_i;
    logic          busy_c, strobe_c, done_c, to_c, uc_c;
    logic [W-1:0]  mask_c;

    int cyc = 0;
    int n_chk = 0;
    int n_bad = 0;
    int n_strobe = 0;
    int n_strobe_c = 0;
    int n_done = 0;
    logic [W-1:0] slog [0:7];

    always #5 clk = ~clk;

    dsi_irq_recovery #(
        .STAT_W (W), .CYC_PER_US (CPU), .POLL_US (PUS), .POLL_LIMIT (LIMIT),
        .DRAIN_ON_CONTENTION (1'b0)
    ) dut_i (
        .clk (clk), .rst_n (rst_n), .start (start_i), .irq_status (irq_q),
        .fifo_status (fifo), .busy (busy_i), .clr_strobe (strobe_i),
        .clr_mask (mask_i), .done (done_i), .err_timeout (to_i),
        .err_uncleared (uc_i)
    );

    dsi_irq_recovery #(
        .STAT_W (W), .CYC_PER_US (CPU), .POLL_US (PUS), .POLL_LIMIT (LIMIT),
        .DRAIN_ON_CONTENTION (1'b1)
    ) dut_c (
        .clk (clk), .rst_n (rst_n), .start (start_c), .irq_status (irq_q),
        .fifo_status (fifo), .busy (busy_c), .clr_strobe (strobe_c),
        .clr_mask (mask_c), .done (done_c), .err_timeout (to_c),
        .err_uncleared (uc_c)
    );

    // behavioural write-one-to-clear interrupt register
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst_n)        irq_q <= '0;
        else if (load_req) irq_q <= load_val;
        else               irq_q <= irq_q & ~((strobe_i ? mask_i : '0) | (strobe_c ? mask_c : '0));
    end

    // port monitor, sampled away from the clock edge
    always @(negedge clk) begin
        if (strobe_i) begin
            if (n_strobe < 8) slog[n_strobe] = mask_i;
            n_strobe = n_strobe + 1;
        end
        if (strobe_c) n_strobe_c = n_strobe_c + 1;
        if (done_i)   n_done = n_done + 1;
    end

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic load_irq(input logic [W-1:0] v);
        @(negedge clk);
        load_val = v;
        load_req = 1'b1;
        @(negedge clk);
        load_req = 1'b0;
    endtask

    // start dut_i, return cycle of start edge and cycle where done was seen
    task automatic run_i(output int t0, output int td, output int ts);
        n_strobe = 0;
        n_done   = 0;
        ts = -1;
        @(negedge clk);
        start_i = 1'b1;
        t0 = cyc + 1;
        @(negedge clk);
        start_i = 1'b0;
        td = -1;
        for (int k = 0; k < 400 && td < 0; k++) begin
            if (strobe_i && ts < 0) ts = cyc;
            if (done_i) td = cyc;
            else @(negedge clk);
        end
    endtask

    task automatic run_c(output int td);
        n_strobe_c = 0;
        @(negedge clk);
        start_c = 1'b1;
        @(negedge clk);
        start_c = 1'b0;
        td = -1;
        for (int k = 0; k < 400 && td < 0; k++) begin
            if (done_c) td = cyc;
            else @(negedge clk);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 busy", 32'(busy_i), 0);
        chk("R1 done", 32'(done_i), 0);
        chk("R1 strobe", 32'(strobe_i), 0);
        chk("R1 mask", mask_i, 0);
        chk("R1 flags", {30'd0, to_i, uc_i}, 0);
    endtask

    task automatic t_empty();
        int t0, td, ts;
        fifo = '1;
        load_irq('0);
        run_i(t0, td, ts);
        chk("R5 empty pass latency", 32'(td - t0), 32);
        chk("R5 no strobe", 32'(n_strobe), 0);
        chk("R8 flags clean", {30'd0, to_i, uc_i}, 0);
        @(negedge clk);
        chk("R8 done single cycle", {30'd0, done_i, busy_i}, 0);
    endtask

    task automatic t_order();
        int t0, td, ts;
        fifo = '1;
        load_irq(32'h5280_0008);
        run_i(t0, td, ts);
        chk("R2 strobe count", 32'(n_strobe), 3);
        chk("R2 R3 first strobe", slog[0], 32'h0080_0000);
        chk("R2 R3 second strobe", slog[1], 32'h0200_0000);
        chk("R2 R4 third strobe", slog[2], 32'h1000_0000);
        chk("R5 untouched bits remain", irq_q, 32'h4000_0008);
        chk("R7 uncleared raised", 32'(uc_i), 1);
        chk("R6 no timeout", 32'(to_i), 0);
        repeat (5) @(negedge clk);
        chk("R8 flag held", 32'(uc_i), 1);
    endtask

    task automatic t_clean();
        int t0, td, ts;
        fifo = HS_E;
        load_irq(32'h0100_0000);
        run_i(t0, td, ts);
        chk("R7 cleared cause not flagged", 32'(uc_i), 0);
        chk("R3 HS wait met by bits 2,18", 32'(to_i), 0);
        chk("R3 cause cleared", irq_q, 0);
    endtask

    task automatic t_hs_timeout();
        int t0, td, ts;
        fifo = LP_E;
        load_irq(32'h0400_0000);
        run_i(t0, td, ts);
        chk("R3 HS wait ignores LP bits", 32'(to_i), 1);
        chk("R6 strobe-to-done span", 32'(td - ts), 32'(2 + (LIMIT - 1) * IVL + (31 - 26) + 1));
    endtask

    task automatic t_lp();
        int t0, td, ts;
        fifo = LP_E;
        load_irq(32'h1000_0000);
        run_i(t0, td, ts);
        chk("R4 LP wait met by bits 10,26", 32'(to_i), 0);
        fifo = HS_E;
        load_irq(32'h1000_0000);
        run_i(t0, td, ts);
        chk("R4 LP wait ignores HS bits", 32'(to_i), 1);
    endtask

    // drain the FIFOs on the last permitted poll, then one cycle too late
    task automatic t_late(input int lag, input logic exp_to);
        int ts, td;
        fifo = '0;
        load_irq(32'h0080_0000);
        n_strobe = 0;
        @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        ts = -1;
        for (int k = 0; k < 100 && ts < 0; k++) begin
            if (strobe_i) ts = cyc;
            else @(negedge clk);
        end
        repeat (lag) @(negedge clk);
        fifo = HS_E;
        td = -1;
        for (int k = 0; k < 100 && td < 0; k++) begin
            if (done_i) td = cyc;
            else @(negedge clk);
        end
        chk("R6 last-poll boundary", 32'(to_i), 32'(exp_to));
        chk("R6 done timing", 32'(td - ts), 32'(2 + (LIMIT - 1) * IVL + (31 - 23) + 1));
    endtask

    task automatic t_busy_start();
        int td;
        fifo = '0;
        load_irq(32'h0000_0010);
        n_done = 0;
        @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (10) @(negedge clk);
        load_irq('0);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        td = 0;
        for (int k = 0; k < 100 && busy_i; k++) @(negedge clk);
        repeat (3) @(negedge clk);
        chk("R8 start while busy ignored", 32'(n_done), 1);
        chk("R8 busy released", 32'(busy_i), 0);
        chk("R7 flag from first pass kept", 32'(uc_i), 1);
    endtask

    task automatic t_contention();
        int t0, td, ts, tc;
        fifo = '1;
        load_irq(32'h0004_0000);
        run_i(t0, td, ts);
        chk("R9 default: no action latency", 32'(td - t0), 33);
        chk("R9 default: no strobe", 32'(n_strobe), 0);
        fifo = ALL_E & ~32'h0800_0000;
        load_irq(32'h0008_0000);
        run_c(tc);
        chk("R9 drain waits for bit 27", 32'(to_c), 1);
        chk("R9 drain never strobes", 32'(n_strobe_c), 0);
        chk("R9 R7 contention cause stays", 32'(uc_c), 1);
        fifo = ALL_E;
        load_irq(32'h0004_0000);
        run_c(tc);
        chk("R9 drain met by all six bits", 32'(to_c), 0);
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", n_chk + 1, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_reset();
        t_empty();
        t_order();
        t_clean();
        t_hs_timeout();
        t_lp();
        t_late(9, 1'b0);
        t_late(10, 1'b1);
        t_busy_start();
        t_contention();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule